// File: doc/BRIEF.md
# Linear Image Sensor Frame Timing Controller

This block drives a 128-pixel linear light sensor from a fast system clock. It divides the system clock into a slow sensor clock and places a one-clock start pulse on the sensor's serial-start pin. Each frame has exactly 129 sensor clock rising edges. The last edge carries no pixel; it only returns the sensor's shift logic to a known state.

For each of the first 128 edges the block waits a programmable settling delay and then raises a one-cycle convert request to an external ADC. The block takes the ADC's data on the matching done pulse. It then emits a pixel stream carrying a valid strobe, the pixel index, and first-pixel and last-pixel markers. If a conversion has not finished by the next sensor clock edge, the pixel is still emitted, with the value zero, and a sticky overrun flag is set.

The block does not issue the next start until two conditions hold. First, a programmable charge-transfer gap must have passed since the final edge. Second, a programmable integration time must have passed since the 19th edge, which is where the sensor begins integrating the next frame. Frames run back to back while the free-run input is high. Otherwise one frame runs per trigger pulse.

Top module: `line_sensor_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a frame starts, `sens_clk_o`, `sens_si_o`, `adc_req_o`, `pix_valid_o` and `overrun_o` are all low.
- R2: During a frame, every high phase and every low phase of `sens_clk_o` lasts Heff system cycles. Heff is the value of `half_period_i`.
- R3: `sens_si_o` rises while `sens_clk_o` is low, Heff cycles before the first rising edge. It is high at that first edge only, and it falls in the same cycle as the clock's first fall. It never changes while `sens_clk_o` is high.
- R4: Every frame contains exactly 129 rising edges of `sens_clk_o`, after which the clock stays low until the next start.
- R5: The first cycle of a new `sens_si_o` high is at least `xfer_gap_i`+1 cycles after the first high cycle of the previous frame's edge 129.
- R6: That cycle is also at least `integ_i`+1 cycles after the first high cycle of the previous frame's edge 19. With free-run held, the start is exactly max(t129+Heff, t19+`integ_i`, t129+`xfer_gap_i`)+1, where t129 and t19 are the first high cycles of those edges.
- R7: For edges 1 to 128, `adc_req_o` is a single-cycle pulse exactly `settle_i`+1 cycles after the first high cycle of that edge. No request is made on edge 129.
- R8: An `adc_done_i` that arrives while a request is outstanding yields `pix_valid_o` for one cycle in the next cycle. `pix_data_o` then holds `adc_data_i`, and `pix_idx_o` counts 0 to 127 in order, giving 128 pixels per frame. A done pulse with no request outstanding has no effect.
- R9: `pix_sol_o` is high only with the pixel of index 0, and `pix_eol_o` only with the pixel of index 127.
- R10: A done pulse is accepted in the cycle just before the next rising edge. If none has arrived by then, the pixel is emitted in the first high cycle of that edge with data 0 and `overrun_o` high. `overrun_o` stays set until the next `sens_si_o` rise clears it.
- R11: With `free_run_i` low, no frame starts without a `trigger_i` pulse. Any number of trigger pulses during a frame queue exactly one further frame.
- R12: A `half_period_i` value of 0 or 1 acts as 2. In other words, Heff = max(`half_period_i`, 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_run_i | input | 1 | Start frames back to back |
| trigger_i | input | 1 | Single-frame start pulse |
| half_period_i | input | 8 | Sensor clock half-period in system cycles |
| settle_i | input | 8 | Cycles from a rising edge to the convert request, minus one |
| integ_i | input | 16 | Minimum cycles from edge 19 to the next start |
| xfer_gap_i | input | 16 | Minimum cycles from edge 129 to the next start |
| sens_clk_o | output | 1 | Sensor clock |
| sens_si_o | output | 1 | Sensor serial start |
| adc_req_o | output | 1 | ADC convert request pulse |
| adc_done_i | input | 1 | ADC conversion done pulse |
| adc_data_i | input | 12 | ADC result |
| pix_valid_o | output | 1 | Pixel strobe |
| pix_data_o | output | 12 | Pixel value |
| pix_idx_o | output | 7 | Pixel index |
| pix_sol_o | output | 1 | First pixel of line |
| pix_eol_o | output | 1 | Last pixel of line |
| overrun_o | output | 1 | Sticky missed-conversion flag |

## Verification
Two things can fall in the same system cycle: the ADC's done pulse, and the divider tick that launches the next sensor clock edge. The bench provokes this by setting the ADC model's latency so that `settle_i`+1+latency equals 2·Heff−1; the done then lands exactly on that tick. In that case the sample must be taken normally and the new pixel must start. With one cycle more latency, the same pattern must give a zero pixel in the edge cycle and set the overrun flag. The late done that follows must be dropped. The pixel count and each pixel's timing are checked against arithmetic on the measured edge times.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned MIN_HALF = 2;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HIGH,
    SQ_LOW
  } seq_state_e;

  typedef enum logic [1:0] {
    SM_IDLE,
    SM_SETTLE,
    SM_WAIT
  } smp_state_e;
endpackage

// File: rtl/lsc_clk_div.sv
module lsc_clk_div #(
  parameter int unsigned HPW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [HPW-1:0] half_i,
  output logic           tick_o
);
  logic [HPW-1:0] h_eff;
  logic [HPW-1:0] cnt_q;

  assign h_eff  = (half_i < HPW'(lsc_pkg::MIN_HALF)) ? HPW'(lsc_pkg::MIN_HALF) : half_i;
  assign tick_o = run_i && (cnt_q == h_eff - HPW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + HPW'(1);
  end
endmodule

// File: rtl/lsc_frame_seq.sv
module lsc_frame_seq #(
  parameter int unsigned N_PIX      = 128,
  parameter int unsigned INTEG_EDGE = 19,
  parameter int unsigned CW         = 16,
  localparam int unsigned LAST_EDGE = N_PIX + 1,
  localparam int unsigned EW        = $clog2(LAST_EDGE + 1),
  localparam int unsigned IW        = $clog2(N_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          go_i,
  input  logic [CW-1:0] integ_i,
  input  logic [CW-1:0] gap_i,
  output logic          run_o,
  output logic          sclk_o,
  output logic          si_o,
  output logic          start_o,
  output logic          pix_evt_o,
  output logic          end_evt_o,
  output logic [IW-1:0] pix_idx_o
);
  import lsc_pkg::*;

  seq_state_e    state_q;
  logic [EW-1:0] edge_q;
  logic          sclk_q, si_q;
  logic [CW-1:0] cnt_int_q, cnt_gap_q;
  logic          ready, int_hit;

  assign ready     = (cnt_int_q >= integ_i) && (cnt_gap_q >= gap_i);
  assign start_o   = (state_q == SQ_IDLE) && go_i && ready;
  assign pix_evt_o = tick_i && ((state_q == SQ_SETUP) ||
                     ((state_q == SQ_LOW) && (edge_q < EW'(N_PIX))));
  assign end_evt_o = tick_i && (state_q == SQ_LOW) && (edge_q == EW'(N_PIX));
  assign pix_idx_o = (state_q == SQ_SETUP) ? '0 : edge_q[IW-1:0];
  assign run_o     = (state_q != SQ_IDLE);
  assign sclk_o    = sclk_q;
  assign si_o      = si_q;

  // edge that begins the next integration window
  generate
    if (INTEG_EDGE == 1) begin : g_int_first
      assign int_hit = tick_i && (state_q == SQ_SETUP);
    end else begin : g_int_later
      assign int_hit = tick_i && (state_q == SQ_LOW) && (edge_q == EW'(INTEG_EDGE - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_int_q <= '1;
      cnt_gap_q <= '1;
    end else begin
      if (int_hit)                cnt_int_q <= '0;
      else if (cnt_int_q != '1)   cnt_int_q <= cnt_int_q + CW'(1);
      if (end_evt_o)              cnt_gap_q <= '0;
      else if (cnt_gap_q != '1)   cnt_gap_q <= cnt_gap_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
      si_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_o) begin
          si_q    <= 1'b1;
          edge_q  <= '0;
          state_q <= SQ_SETUP;
        end
        SQ_SETUP: if (tick_i) begin
          sclk_q  <= 1'b1;
          edge_q  <= EW'(1);
          state_q <= SQ_HIGH;
        end
        SQ_HIGH: if (tick_i) begin
          sclk_q <= 1'b0;
          if (edge_q == EW'(1)) si_q <= 1'b0;
          state_q <= (edge_q == EW'(LAST_EDGE)) ? SQ_IDLE : SQ_LOW;
        end
        SQ_LOW: if (tick_i) begin
          sclk_q  <= 1'b1;
          edge_q  <= edge_q + EW'(1);
          state_q <= SQ_HIGH;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsc_pix_sampler.sv
module lsc_pix_sampler #(
  parameter int unsigned N_PIX = 128,
  parameter int unsigned DW    = 12,
  parameter int unsigned SW    = 8,
  localparam int unsigned IW   = $clog2(N_PIX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          pix_evt_i,
  input  logic          end_evt_i,
  input  logic [IW-1:0] idx_i,
  input  logic [SW-1:0] settle_i,
  input  logic          adc_done_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          adc_req_o,
  output logic          pix_valid_o,
  output logic [DW-1:0] pix_data_o,
  output logic [IW-1:0] pix_idx_o,
  output logic          pix_sol_o,
  output logic          pix_eol_o,
  output logic          overrun_o
);
  import lsc_pkg::*;

  smp_state_e    state_q;
  logic [SW-1:0] dcnt_q;
  logic [IW-1:0] cur_q;
  logic          got, evt;

  assign got = (state_q == SM_WAIT) && adc_done_i;
  assign evt = pix_evt_i || end_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SM_IDLE;
      dcnt_q      <= '0;
      cur_q       <= '0;
      adc_req_o   <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      pix_idx_o   <= '0;
      pix_sol_o   <= 1'b0;
      pix_eol_o   <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      adc_req_o   <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_sol_o   <= 1'b0;
      pix_eol_o   <= 1'b0;
      if (frame_start_i) overrun_o <= 1'b0;

      // emit: completed sample, or zero when the next edge preempts
      if (got) begin
        pix_valid_o <= 1'b1;
        pix_data_o  <= adc_data_i;
        pix_idx_o   <= cur_q;
        pix_sol_o   <= (cur_q == '0);
        pix_eol_o   <= (cur_q == IW'(N_PIX - 1));
        state_q     <= SM_IDLE;
      end else if (evt && (state_q != SM_IDLE)) begin
        pix_valid_o <= 1'b1;
        pix_data_o  <= '0;
        pix_idx_o   <= cur_q;
        pix_sol_o   <= (cur_q == '0);
        pix_eol_o   <= (cur_q == IW'(N_PIX - 1));
        overrun_o   <= 1'b1;
      end

      if (pix_evt_i) begin
        state_q <= SM_SETTLE;
        dcnt_q  <= settle_i;
        cur_q   <= idx_i;
      end else if (end_evt_i) begin
        state_q <= SM_IDLE;
      end else if (!got && (state_q == SM_SETTLE)) begin
        if (dcnt_q == '0) begin
          adc_req_o <= 1'b1;
          state_q   <= SM_WAIT;
        end else begin
          dcnt_q <= dcnt_q - SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/line_sensor_ctrl.sv
module line_sensor_ctrl #(
  parameter int unsigned N_PIX      = 128,
  parameter int unsigned INTEG_EDGE = 19,
  parameter int unsigned DW         = 12,
  parameter int unsigned HPW        = 8,
  parameter int unsigned SW         = 8,
  parameter int unsigned CW         = 16,
  localparam int unsigned IW        = $clog2(N_PIX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           free_run_i,
  input  logic           trigger_i,
  input  logic [HPW-1:0] half_period_i,
  input  logic [SW-1:0]  settle_i,
  input  logic [CW-1:0]  integ_i,
  input  logic [CW-1:0]  xfer_gap_i,
  output logic           sens_clk_o,
  output logic           sens_si_o,
  output logic           adc_req_o,
  input  logic           adc_done_i,
  input  logic [DW-1:0]  adc_data_i,
  output logic           pix_valid_o,
  output logic [DW-1:0]  pix_data_o,
  output logic [IW-1:0]  pix_idx_o,
  output logic           pix_sol_o,
  output logic           pix_eol_o,
  output logic           overrun_o
);
  logic          run, tick, start, pix_evt, end_evt, go, trig_q;
  logic [IW-1:0] evt_idx;

  assign go = free_run_i || trig_q || trigger_i;

  // one queued frame per trigger burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        trig_q <= 1'b0;
    else if (start)     trig_q <= 1'b0;
    else if (trigger_i) trig_q <= 1'b1;
  end

  lsc_clk_div #(.HPW(HPW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half_period_i),
    .tick_o (tick)
  );

  lsc_frame_seq #(.N_PIX(N_PIX), .INTEG_EDGE(INTEG_EDGE), .CW(CW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .go_i      (go),
    .integ_i   (integ_i),
    .gap_i     (xfer_gap_i),
    .run_o     (run),
    .sclk_o    (sens_clk_o),
    .si_o      (sens_si_o),
    .start_o   (start),
    .pix_evt_o (pix_evt),
    .end_evt_o (end_evt),
    .pix_idx_o (evt_idx)
  );

  lsc_pix_sampler #(.N_PIX(N_PIX), .DW(DW), .SW(SW)) u_smp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (start),
    .pix_evt_i     (pix_evt),
    .end_evt_i     (end_evt),
    .idx_i         (evt_idx),
    .settle_i      (settle_i),
    .adc_done_i    (adc_done_i),
    .adc_data_i    (adc_data_i),
    .adc_req_o     (adc_req_o),
    .pix_valid_o   (pix_valid_o),
    .pix_data_o    (pix_data_o),
    .pix_idx_o     (pix_idx_o),
    .pix_sol_o     (pix_sol_o),
    .pix_eol_o     (pix_eol_o),
    .overrun_o     (overrun_o)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int unsigned N_PIX = 128,
  parameter int unsigned DW    = 12,
  parameter int unsigned CW    = 16,
  localparam int unsigned IW   = $clog2(N_PIX)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sens_clk_o,
  input logic          sens_si_o,
  input logic          adc_req_o,
  input logic [CW-1:0] xfer_gap_i,
  input logic          pix_valid_o,
  input logic [DW-1:0] pix_data_o,
  input logic [IW-1:0] pix_idx_o,
  input logic          pix_sol_o,
  input logic          pix_eol_o,
  input logic          overrun_o
);
  logic        clk_d, si_d, rose_clk, rose_si;
  logic [8:0]  e_cnt;
  logic [1:0]  si_edges;
  logic [CW:0] gap_c;

  assign rose_clk = sens_clk_o && !clk_d;
  assign rose_si  = sens_si_o && !si_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d    <= 1'b0;
      si_d     <= 1'b0;
      e_cnt    <= '0;
      si_edges <= '0;
      gap_c    <= '1;
    end else begin
      clk_d <= sens_clk_o;
      si_d  <= sens_si_o;
      if (rose_si)       e_cnt <= '0;
      else if (rose_clk) e_cnt <= e_cnt + 9'd1;
      if (!sens_si_o)                     si_edges <= '0;
      else if (rose_clk && si_edges != 2'd3) si_edges <= si_edges + 2'd1;
      if (rose_clk && e_cnt == 9'(N_PIX)) gap_c <= (CW+1)'(1);
      else if (gap_c != '1)               gap_c <= gap_c + (CW+1)'(1);
    end
  end

  a_r3_si_moves_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sens_si_o != si_d) |-> !sens_clk_o);
  a_r3_si_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rose_clk && sens_si_o) |-> (si_edges == 2'd0));
  a_r4_edges_per_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rose_si |-> (e_cnt == 9'd0 || e_cnt == 9'(N_PIX + 1)));
  a_r4_no_extra_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rose_clk |-> (e_cnt <= 9'(N_PIX)));
  a_r5_gap_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rose_si |-> (gap_c > {1'b0, xfer_gap_i}));
  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |=> !adc_req_o);
  a_r7_req_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |-> (e_cnt >= 9'd1 && e_cnt <= 9'(N_PIX)));
  a_r9_sol_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sol_o |-> (pix_valid_o && pix_idx_o == '0));
  a_r9_eol_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_eol_o |-> (pix_valid_o && pix_idx_o == IW'(N_PIX - 1)));
  a_r10_overrun_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (pix_valid_o && pix_data_o == '0));
endmodule

bind line_sensor_ctrl lsc_checker #(.N_PIX(N_PIX), .DW(DW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sens_clk_o  (sens_clk_o),
  .sens_si_o   (sens_si_o),
  .adc_req_o   (adc_req_o),
  .xfer_gap_i  (xfer_gap_i),
  .pix_valid_o (pix_valid_o),
  .pix_data_o  (pix_data_o),
  .pix_idx_o   (pix_idx_o),
  .pix_sol_o   (pix_sol_o),
  .pix_eol_o   (pix_eol_o),
  .overrun_o   (overrun_o)
);

// File: tb/line_sensor_ctrl_test.sv
module line_sensor_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 128;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        free_run = 1'b0, trigger = 1'b0;
  logic [7:0]  half_p = 8'd2, settle = 8'd0;
  logic [15:0] integ = 16'd0, gap = 16'd0;
  logic        sclk, si, req, done = 1'b0, pv, sol, eol, ovr;
  logic [11:0] adc_data = '0, pdata;
  logic [6:0]  pidx;

  line_sensor_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .free_run_i(free_run), .trigger_i(trigger),
    .half_period_i(half_p), .settle_i(settle), .integ_i(integ), .xfer_gap_i(gap),
    .sens_clk_o(sclk), .sens_si_o(si), .adc_req_o(req), .adc_done_i(done),
    .adc_data_i(adc_data), .pix_valid_o(pv), .pix_data_o(pdata), .pix_idx_o(pidx),
    .pix_sol_o(sol), .pix_eol_o(eol), .overrun_o(ovr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int heff = 2, lat = 0;
  int fe = 0, nfr = 0, eol_cnt = 0, pix_cnt = 0, req_k = 0;
  int t_si = 0, t19 = 0, t129 = 0, done_at = -1, done_k = 0;
  int t_rise[0:131];
  int t_req[0:NP-1];
  bit prev_free = 0, spur = 0, pclk = 0, psi = 0;

  function automatic int fdat(int k);
    return (k * 37 + 5) % 4096;
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (si && !psi) begin
        chk(sclk == 1'b0, "R3 si rises with clock low", int'(sclk), 0);
        chk(ovr == 1'b0, "R10 overrun cleared at start", int'(ovr), 0);
        if (nfr > 0) begin
          chk(fe == 129, "R4 edges in frame", fe, 129);
          chk(pix_cnt == NP, "R8 pixels per frame", pix_cnt, NP);
          chk(cyc - t129 >= int'(gap) + 1, "R5 transfer gap", cyc - t129, int'(gap) + 1);
          chk(cyc - t19 >= int'(integ) + 1, "R6 integration time", cyc - t19, int'(integ) + 1);
          if (prev_free && free_run) begin
            int e;
            e = t129 + heff;
            if (t19 + int'(integ) > e) e = t19 + int'(integ);
            if (t129 + int'(gap) > e) e = t129 + int'(gap);
            chk(cyc == e + 1, "R6 free-run start cycle", cyc, e + 1);
          end
        end
        prev_free = free_run;
        fe = 0; pix_cnt = 0; req_k = 0; t_si = cyc; nfr++;
      end
      if (sclk && !pclk) begin
        fe++;
        t_rise[fe] = cyc;
        if (fe == 1) begin
          chk(cyc - t_si == heff, "R3 si lead before edge 1", cyc - t_si, heff);
          chk(si == 1'b1, "R3 si high at edge 1", int'(si), 1);
        end else begin
          chk(cyc - t_rise[fe-1] == 2 * heff, "R2 R12 clock period", cyc - t_rise[fe-1], 2 * heff);
          if (fe == 2) chk(si == 1'b0, "R3 si low at edge 2", int'(si), 0);
        end
        if (fe == 19) t19 = cyc;
        if (fe == 129) t129 = cyc;
        chk(fe <= 129, "R4 no edge past 129", fe, 129);
      end
      if (!sclk && pclk) begin
        chk(cyc - t_rise[fe] == heff, "R2 high phase", cyc - t_rise[fe], heff);
        if (fe == 1) chk(si == 1'b0, "R3 si falls with clock", int'(si), 0);
      end
      if (req) begin
        chk(fe >= 1 && fe <= NP, "R7 request only on pixel edges", fe, NP);
        if (fe >= 1 && fe <= NP)
          chk(cyc == t_rise[fe] + int'(settle) + 1, "R7 request delay",
              cyc - t_rise[fe], int'(settle) + 1);
        if (req_k < NP) t_req[req_k] = cyc;
        done_at = cyc + lat; done_k = req_k; req_k++;
      end
      if (pv) begin
        bit ov;
        int et;
        ov = (int'(settle) + 1 + lat) > (2 * heff - 1);
        et = ov ? t_rise[pix_cnt + 2] : t_req[pix_cnt] + lat + 1;
        chk(pix_cnt < NP, "R8 no extra pixel", pix_cnt, NP - 1);
        chk(int'(pidx) == pix_cnt, "R8 pixel index", int'(pidx), pix_cnt);
        chk(int'(pdata) == (ov ? 0 : fdat(pix_cnt)), ov ? "R10 zero on overrun" : "R8 pixel data",
            int'(pdata), ov ? 0 : fdat(pix_cnt));
        chk(cyc == et, ov ? "R10 overrun pixel timing" : "R8 pixel timing", cyc, et);
        chk(ovr == ov, "R10 overrun flag", int'(ovr), int'(ov));
        chk(sol == (pix_cnt == 0), "R9 start-of-line", int'(sol), int'(pix_cnt == 0));
        chk(eol == (pix_cnt == NP - 1), "R9 end-of-line", int'(eol), int'(pix_cnt == NP - 1));
        if (eol) eol_cnt++;
        pix_cnt++;
      end
      pclk = sclk; psi = si;
    end
    done = (cyc == done_at) || spur;
    adc_data = (cyc == done_at) ? 12'(fdat(done_k)) : 12'hABC;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic set_cfg(input int h, input int s, input int l, input int g, input int it);
    half_p = 8'(h); settle = 8'(s); lat = l; gap = 16'(g); integ = 16'(it);
    heff = (h < 2) ? 2 : h;
  endtask

  task automatic run_free(input int h, input int s, input int l, input int g, input int it, input int n);
    int target;
    @(negedge clk);
    set_cfg(h, s, l, g, it);
    prev_free = 0;
    target = eol_cnt + n;
    free_run = 1'b1;
    wait (eol_cnt >= target);
    free_run = 1'b0;
    repeat (6 * heff + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 0 && si == 0 && req == 0 && pv == 0 && ovr == 0, "R1 outputs in reset",
        int'({sclk, si, req, pv, ovr}), 0);
    rst_n = 1'b1;
    set_cfg(2, 0, 2, 4, 0);
    repeat (30) @(negedge clk);
    chk(sclk == 0 && si == 0 && req == 0 && pv == 0 && ovr == 0, "R1 idle after reset",
        int'({sclk, si, req, pv, ovr}), 0);
    chk(nfr == 0, "R11 no frame without trigger", nfr, 0);
    // spurious done with nothing outstanding
    spur = 1'b1; @(negedge clk); spur = 1'b0; @(negedge clk);
    chk(pv == 1'b0, "R8 stray done ignored", int'(pv), 0);
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    repeat (100) @(negedge clk);
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    repeat (40) @(negedge clk);
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    wait (eol_cnt >= 2);
    repeat (1500) @(negedge clk);
    chk(nfr == 2, "R11 triggers during frame queue one", nfr, 2);
    chk(eol_cnt == 2, "R11 frames completed", eol_cnt, 2);
    run_free(2, 0, 2, 4, 0, 3);    // done on the cycle before the edge
    run_free(2, 0, 3, 4, 0, 2);    // one cycle late: overrun
    run_free(3, 3, 0, 40, 0, 3);   // gap dominates
    run_free(1, 1, 1, 0, 700, 2);  // R12 and integration dominates
    run_free(0, 0, 0, 0, 0, 2);    // R12 zero half-period
    run_free(4, 6, 0, 2, 0, 2);    // settle at its last usable value
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end
endmodule